// File: doc/BRIEF.md
# Complex Givens Rotation Cell (Shift-and-Add)

This block carries out one update step of a QR triangularisation on complex data. It builds every rotation from CORDIC micro-rotations, so the hardware is only shifters, adders and subtractors. The cell holds two stored elements. The first is a real, non-negative diagonal value kept in the boundary part. The second is a complex off-diagonal value kept in the internal part.

When a new pair of complex samples is accepted, the update runs in two stages. In the first stage the boundary part turns its incoming sample onto the positive real axis and records the direction taken at each iteration. The internal part replays that same phase rotation on its own sample. In the second stage the boundary part rotates the pair (stored diagonal, real sample) through the real angle that cancels the sample, which yields the new diagonal. The internal part applies the same direction bits to the pair (stored off-diagonal, phase-corrected sample). This gives the new stored value and a residual sample for the next row. A fixed shift-add factor compensates the constant CORDIC gain after each stage.

The cell is iterative: one micro-rotation per clock per stage. It produces one result pulse a fixed number of cycles after it accepts an input.

Top module: `cplx_givens_cell`

## Requirements
- R1: After an update with boundary sample x (not zero) and stored diagonal r, the stored diagonal equals sqrt(r^2 + |x|^2) within 32 LSB.
- R2: After the same update, the stored off-diagonal value equals (r*o + conj(x)*y)/rho within 32 LSB per component. Here o is the previous off-diagonal value, y is the internal sample and rho is the new diagonal.
- R3: The residual output equals e^(-j*arg x) * (r*y - x*o)/rho within 32 LSB per component.
- R4: The stored diagonal is never negative. This holds for boundary samples in every quadrant, including a negative real part and samples on the axes.
- R5: An all-zero boundary sample leaves the diagonal and the off-diagonal value unchanged. The residual output then equals the internal sample exactly.
- R6: The output valid flag is a single-cycle pulse. It rises 2*ITER clock cycles (28 at default) after the edge on which the input was accepted. The stored elements update on that same edge.
- R7: in_valid asserted while an update is in progress is ignored. It causes no extra output pulse and does not affect any stored value.
- R8: After reset, the diagonal, the off-diagonal value and the residual output are zero, and out_valid is low.
- R9: Starting from a zero diagonal, the first update sets the diagonal to |x|. With a zero off-diagonal value it sets the residual close to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample pair present; accepted only when idle |
| bnd_re | input | DW (18) | Boundary sample, real part, signed |
| bnd_im | input | DW (18) | Boundary sample, imaginary part, signed |
| int_re | input | DW (18) | Internal sample, real part, signed |
| int_im | input | DW (18) | Internal sample, imaginary part, signed |
| out_valid | output | 1 | One-cycle pulse marking a new residual |
| out_re | output | DW (18) | Residual to next row, real part, signed |
| out_im | output | DW (18) | Residual to next row, imaginary part, signed |
| diag | output | DW (18) | Stored diagonal element, signed and non-negative |
| off_re | output | DW (18) | Stored off-diagonal element, real part |
| off_im | output | DW (18) | Stored off-diagonal element, imaginary part |

## Verification
The sweep steps the boundary sample through sixteen phase angles at two magnitudes. Each update builds on the state left by the previous one, so the growing diagonal and the changing off-diagonal value exercise the second-stage angle over its whole range. Samples placed exactly on the negative real axis and the imaginary axes separate a correct quadrant pre-flip from one that handles only the right half-plane. An all-zero boundary sample and an input pulse inside the busy window separate the exact bypass and the input-ignore rule from ordinary rotation results. Each expected value comes from the closed-form complex Givens formulas applied to the previous stored values read at the ports.

// File: rtl/cgv_pkg.sv
package cgv_pkg;
    parameter int CGV_DW   = 18;  // sample and stored element width
    parameter int CGV_ITER = 14;  // micro-rotations per stage
    parameter int CGV_FB   = 2;   // extra fraction bits inside the datapath
    parameter int CGV_GB   = 3;   // growth guard bits inside the datapath

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PHASE = 2'd1,
        ST_ROT   = 2'd2
    } cgv_state_e;
endpackage

// File: rtl/cgv_boundary.sv
module cgv_boundary
    import cgv_pkg::*;
#(
    parameter int DW   = CGV_DW,
    parameter int ITER = CGV_ITER,
    parameter int FB   = CGV_FB,
    parameter int GB   = CGV_GB,
    localparam int IW  = DW + GB + FB,
    localparam int SW  = (ITER > 1) ? $clog2(ITER) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] bx_re,
    input  logic signed [DW-1:0] bx_im,
    output logic signed [DW-1:0] diag_o,
    output logic                 load_o,
    output logic                 flip_o,
    output logic                 ph_o,
    output logic                 rt_o,
    output logic                 skip_o,
    output logic [SW-1:0]        shamt_o,
    output logic                 dir_o,
    output logic                 ph_last_o,
    output logic                 rt_last_o
);
    localparam logic signed [IW-1:0] HI = IW'((1 <<< (DW - 1)) - 1);
    localparam logic signed [IW-1:0] LO = -HI - 1;

    typedef struct packed {
        cgv_state_e            st;
        logic [SW-1:0]         it;
        logic signed [IW-1:0]  x;
        logic signed [IW-1:0]  y;
        logic signed [DW-1:0]  diag;
        logic                  zero;
    } bnd_s;

    bnd_s b_d, b_q;

    function automatic logic signed [IW-1:0] widen(input logic signed [DW-1:0] v);
        return IW'(v) <<< FB;
    endfunction

    // multiply by about 0.6074 to cancel the CORDIC gain
    function automatic logic signed [IW-1:0] gain_fix(input logic signed [IW-1:0] v);
        return (v >>> 1) + (v >>> 3) - (v >>> 6) - (v >>> 9);
    endfunction

    function automatic logic signed [DW-1:0] narrow(input logic signed [IW-1:0] v);
        logic signed [IW-1:0] t;
        t = v >>> FB;
        if (t > HI) t = HI;
        else if (t < LO) t = LO;
        return t[DW-1:0];
    endfunction

    logic                 dir;
    logic signed [IW-1:0] xs, ys, xn, yn;

    always_comb begin
        b_d       = b_q;
        dir       = ~b_q.y[IW-1];
        xs        = b_q.x >>> b_q.it;
        ys        = b_q.y >>> b_q.it;
        xn        = dir ? (b_q.x + ys) : (b_q.x - ys);
        yn        = dir ? (b_q.y - xs) : (b_q.y + xs);
        load_o    = 1'b0;
        ph_last_o = 1'b0;
        rt_last_o = 1'b0;
        case (b_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    load_o    = 1'b1;
                    b_d.x     = bx_re[DW-1] ? -widen(bx_re) : widen(bx_re);
                    b_d.y     = bx_re[DW-1] ? -widen(bx_im) : widen(bx_im);
                    b_d.zero  = (bx_re == '0) && (bx_im == '0);
                    b_d.st    = ST_PHASE;
                    b_d.it    = '0;
                end
            end
            ST_PHASE: begin
                if (!b_q.zero) begin
                    b_d.x = xn;
                    b_d.y = yn;
                end
                if (b_q.it == SW'(ITER - 1)) begin
                    ph_last_o = 1'b1;
                    b_d.st    = ST_ROT;
                    b_d.it    = '0;
                    b_d.x     = widen(b_q.diag);
                    b_d.y     = b_q.zero ? '0 : gain_fix(xn);
                end else begin
                    b_d.it = b_q.it + 1'b1;
                end
            end
            ST_ROT: begin
                if (!b_q.zero) begin
                    b_d.x = xn;
                    b_d.y = yn;
                end
                if (b_q.it == SW'(ITER - 1)) begin
                    rt_last_o = 1'b1;
                    b_d.st    = ST_IDLE;
                    b_d.it    = '0;
                    if (!b_q.zero) b_d.diag = narrow(gain_fix(xn));
                end else begin
                    b_d.it = b_q.it + 1'b1;
                end
            end
            default: b_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign diag_o  = b_q.diag;
    assign flip_o  = bx_re[DW-1];
    assign ph_o    = (b_q.st == ST_PHASE);
    assign rt_o    = (b_q.st == ST_ROT);
    assign skip_o  = b_q.zero;
    assign shamt_o = b_q.it;
    assign dir_o   = dir;

    AST_DIAG_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        !b_q.diag[DW-1]); // R4
    AST_PHASE_XPOS: assert property (@(posedge clk) disable iff (!rst_n)
        (b_q.st == ST_PHASE) |-> !b_q.x[IW-1]); // R4
    AST_ROT_XPOS: assert property (@(posedge clk) disable iff (!rst_n)
        (b_q.st == ST_ROT) |-> !b_q.x[IW-1]); // R1
    AST_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_last_o && b_q.zero) |=> $stable(b_q.diag)); // R5
endmodule

// File: rtl/cgv_internal.sv
module cgv_internal
    import cgv_pkg::*;
#(
    parameter int DW   = CGV_DW,
    parameter int ITER = CGV_ITER,
    parameter int FB   = CGV_FB,
    parameter int GB   = CGV_GB,
    localparam int IW  = DW + GB + FB,
    localparam int SW  = (ITER > 1) ? $clog2(ITER) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] xi_re,
    input  logic signed [DW-1:0] xi_im,
    input  logic                 load_i,
    input  logic                 flip_i,
    input  logic                 ph_i,
    input  logic                 rt_i,
    input  logic                 skip_i,
    input  logic [SW-1:0]        shamt_i,
    input  logic                 dir_i,
    input  logic                 ph_last_i,
    input  logic                 rt_last_i,
    output logic signed [DW-1:0] off_re_o,
    output logic signed [DW-1:0] off_im_o,
    output logic signed [DW-1:0] out_re_o,
    output logic signed [DW-1:0] out_im_o,
    output logic                 out_valid_o
);
    localparam logic signed [IW-1:0] HI = IW'((1 <<< (DW - 1)) - 1);
    localparam logic signed [IW-1:0] LO = -HI - 1;

    typedef struct packed {
        logic signed [IW-1:0] u_re;
        logic signed [IW-1:0] u_im;
        logic signed [IW-1:0] v_re;
        logic signed [IW-1:0] v_im;
        logic signed [DW-1:0] off_re;
        logic signed [DW-1:0] off_im;
        logic signed [DW-1:0] o_re;
        logic signed [DW-1:0] o_im;
        logic                 ovld;
    } int_s;

    int_s i_d, i_q;

    function automatic logic signed [IW-1:0] widen(input logic signed [DW-1:0] v);
        return IW'(v) <<< FB;
    endfunction

    function automatic logic signed [IW-1:0] gain_fix(input logic signed [IW-1:0] v);
        return (v >>> 1) + (v >>> 3) - (v >>> 6) - (v >>> 9);
    endfunction

    function automatic logic signed [DW-1:0] narrow(input logic signed [IW-1:0] v);
        logic signed [IW-1:0] t;
        t = v >>> FB;
        if (t > HI) t = HI;
        else if (t < LO) t = LO;
        return t[DW-1:0];
    endfunction

    logic signed [IW-1:0] ph_re, ph_im;           // phase replay on the sample
    logic signed [IW-1:0] ur_n, vr_n, ui_n, vi_n; // real-angle replay on the pair

    always_comb begin
        i_d      = i_q;
        i_d.ovld = 1'b0;

        ph_re = dir_i ? (i_q.v_re + (i_q.v_im >>> shamt_i)) : (i_q.v_re - (i_q.v_im >>> shamt_i));
        ph_im = dir_i ? (i_q.v_im - (i_q.v_re >>> shamt_i)) : (i_q.v_im + (i_q.v_re >>> shamt_i));

        ur_n = dir_i ? (i_q.u_re + (i_q.v_re >>> shamt_i)) : (i_q.u_re - (i_q.v_re >>> shamt_i));
        vr_n = dir_i ? (i_q.v_re - (i_q.u_re >>> shamt_i)) : (i_q.v_re + (i_q.u_re >>> shamt_i));
        ui_n = dir_i ? (i_q.u_im + (i_q.v_im >>> shamt_i)) : (i_q.u_im - (i_q.v_im >>> shamt_i));
        vi_n = dir_i ? (i_q.v_im - (i_q.u_im >>> shamt_i)) : (i_q.v_im + (i_q.u_im >>> shamt_i));

        if (load_i) begin
            i_d.v_re = flip_i ? -widen(xi_re) : widen(xi_re);
            i_d.v_im = flip_i ? -widen(xi_im) : widen(xi_im);
        end

        if (ph_i && !skip_i) begin
            i_d.v_re = ph_re;
            i_d.v_im = ph_im;
        end
        if (ph_last_i) begin
            i_d.u_re = widen(i_q.off_re);
            i_d.u_im = widen(i_q.off_im);
            if (!skip_i) begin
                i_d.v_re = gain_fix(ph_re);
                i_d.v_im = gain_fix(ph_im);
            end
        end

        if (rt_i && !skip_i) begin
            i_d.u_re = ur_n;
            i_d.v_re = vr_n;
            i_d.u_im = ui_n;
            i_d.v_im = vi_n;
        end
        if (rt_last_i) begin
            i_d.ovld = 1'b1;
            if (skip_i) begin
                i_d.o_re = narrow(i_q.v_re);
                i_d.o_im = narrow(i_q.v_im);
            end else begin
                i_d.off_re = narrow(gain_fix(ur_n));
                i_d.off_im = narrow(gain_fix(ui_n));
                i_d.o_re   = narrow(gain_fix(vr_n));
                i_d.o_im   = narrow(gain_fix(vi_n));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) i_q <= '0;
        else        i_q <= i_d;
    end

    assign off_re_o    = i_q.off_re;
    assign off_im_o    = i_q.off_im;
    assign out_re_o    = i_q.o_re;
    assign out_im_o    = i_q.o_im;
    assign out_valid_o = i_q.ovld;

    AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        i_q.ovld |=> !i_q.ovld); // R6
    AST_OUT_AFTER_ROT: assert property (@(posedge clk) disable iff (!rst_n)
        i_q.ovld |-> $past(rt_last_i)); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(ph_i || rt_i) |=> ($stable(i_q.off_re) && $stable(i_q.off_im))); // R7
endmodule

// File: rtl/cplx_givens_cell.sv
module cplx_givens_cell
    import cgv_pkg::*;
#(
    parameter int DW   = CGV_DW,
    parameter int ITER = CGV_ITER,
    parameter int FB   = CGV_FB,
    parameter int GB   = CGV_GB,
    localparam int SW  = (ITER > 1) ? $clog2(ITER) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] bnd_re,
    input  logic signed [DW-1:0] bnd_im,
    input  logic signed [DW-1:0] int_re,
    input  logic signed [DW-1:0] int_im,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_re,
    output logic signed [DW-1:0] out_im,
    output logic signed [DW-1:0] diag,
    output logic signed [DW-1:0] off_re,
    output logic signed [DW-1:0] off_im
);
    logic          load, flip, ph, rt, skip, dir, ph_last, rt_last;
    logic [SW-1:0] shamt;

    cgv_boundary #(.DW(DW), .ITER(ITER), .FB(FB), .GB(GB)) u_bnd (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .bx_re     (bnd_re),
        .bx_im     (bnd_im),
        .diag_o    (diag),
        .load_o    (load),
        .flip_o    (flip),
        .ph_o      (ph),
        .rt_o      (rt),
        .skip_o    (skip),
        .shamt_o   (shamt),
        .dir_o     (dir),
        .ph_last_o (ph_last),
        .rt_last_o (rt_last)
    );

    cgv_internal #(.DW(DW), .ITER(ITER), .FB(FB), .GB(GB)) u_int (
        .clk         (clk),
        .rst_n       (rst_n),
        .xi_re       (int_re),
        .xi_im       (int_im),
        .load_i      (load),
        .flip_i      (flip),
        .ph_i        (ph),
        .rt_i        (rt),
        .skip_i      (skip),
        .shamt_i     (shamt),
        .dir_i       (dir),
        .ph_last_i   (ph_last),
        .rt_last_i   (rt_last),
        .off_re_o    (off_re),
        .off_im_o    (off_im),
        .out_re_o    (out_re),
        .out_im_o    (out_im),
        .out_valid_o (out_valid)
    );
endmodule

// File: tb/cplx_givens_cell_tb.sv
module cplx_givens_cell_tb;
    localparam int  DW  = 18;
    localparam int  LAT = 28;
    localparam int  TOL = 32;
    localparam real PI  = 3.14159265358979;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] bnd_re = '0, bnd_im = '0, int_re = '0, int_im = '0;
    logic                 out_valid;
    logic signed [DW-1:0] out_re, out_im, diag, off_re, off_im;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cplx_givens_cell u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .bnd_re(bnd_re), .bnd_im(bnd_im), .int_re(int_re), .int_im(int_im),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im),
        .diag(diag), .off_re(off_re), .off_im(off_im)
    );

    task automatic chk(input string req, input int act, input real exp, input int tol);
        real d;
        checks++;
        d = real'(act) - exp;
        if (d < 0.0) d = -d;
        if (d > real'(tol)) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0.2f", req, act, exp);
        end
    endtask

    function automatic int rnd(input real v);
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    endfunction

    // one update; poke>0 injects a second in_valid pulse that many cycles into the busy window
    task automatic update(input int bre, input int bim, input int ire, input int iim,
                          input int poke, input string tag);
        real r, ore, oim, mx2, rho, tre, tim, e_d, e_ore, e_oim, e_yre, e_yim;
        int  lat;
        r   = real'(int'(diag));
        ore = real'(int'(off_re));
        oim = real'(int'(off_im));
        @(negedge clk);
        bnd_re = DW'(bre); bnd_im = DW'(bim); int_re = DW'(ire); int_im = DW'(iim);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        lat = 0;
        for (int k = 1; k <= LAT + 10; k++) begin
            @(negedge clk);
            if (poke > 0 && k == poke) begin
                bnd_re = DW'(9000); bnd_im = DW'(-9000); int_re = DW'(7000); int_im = DW'(5000);
                in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
            if (out_valid) begin
                lat = k;
                break;
            end
        end
        in_valid = 1'b0;
        chk({"R6 latency ", tag}, lat, real'(LAT), 0);
        mx2 = real'(bre) * real'(bre) + real'(bim) * real'(bim);
        if (mx2 == 0.0) begin
            chk({"R5 diag ", tag}, int'(diag), r, 0);
            chk({"R5 off_re ", tag}, int'(off_re), ore, 0);
            chk({"R5 off_im ", tag}, int'(off_im), oim, 0);
            chk({"R5 out_re ", tag}, int'(out_re), real'(ire), 0);
            chk({"R5 out_im ", tag}, int'(out_im), real'(iim), 0);
        end else begin
            rho   = $sqrt(r * r + mx2);
            e_d   = rho;
            e_ore = (r * ore + real'(bre) * real'(ire) + real'(bim) * real'(iim)) / rho;
            e_oim = (r * oim + real'(bre) * real'(iim) - real'(bim) * real'(ire)) / rho;
            tre   = r * real'(ire) - (real'(bre) * ore - real'(bim) * oim);
            tim   = r * real'(iim) - (real'(bre) * oim + real'(bim) * ore);
            e_yre = (real'(bre) * tre + real'(bim) * tim) / ($sqrt(mx2) * rho);
            e_yim = (real'(bre) * tim - real'(bim) * tre) / ($sqrt(mx2) * rho);
            chk({"R1 diag ", tag}, int'(diag), e_d, TOL);
            chk({"R2 off_re ", tag}, int'(off_re), e_ore, TOL);
            chk({"R2 off_im ", tag}, int'(off_im), e_oim, TOL);
            chk({"R3 out_re ", tag}, int'(out_re), e_yre, TOL);
            chk({"R3 out_im ", tag}, int'(out_im), e_yim, TOL);
        end
        chk({"R4 diag sign ", tag}, int'(diag < 0), 0.0, 0);
        @(negedge clk);
        chk({"R6 pulse width ", tag}, int'(out_valid), 0.0, 0);
    endtask

    initial begin
        int dsave, orsave, oisave, extra;
        repeat (3) @(negedge clk);
        chk("R8 reset diag", int'(diag), 0.0, 0);
        chk("R8 reset off_re", int'(off_re), 0.0, 0);
        chk("R8 reset off_im", int'(off_im), 0.0, 0);
        chk("R8 reset out", int'(out_re) + int'(out_im), 0.0, 0);
        chk("R8 reset out_valid", int'(out_valid), 0.0, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: first update from an empty diagonal
        update(1200, -1600, 300, 400, 0, "R9 first");
        chk("R9 diag equals |x|", int'(diag), 2000.0, TOL);
        chk("R9 residual near zero", int'(out_re) + int'(out_im), 0.0, 2 * TOL);

        // phase sweep over all quadrants at two magnitudes
        for (int a = 0; a < 16; a++) begin
            for (int m = 0; m < 2; m++) begin
                real ang, angy, mag;
                ang  = (real'(a) * 22.5 + 5.0) * PI / 180.0;
                angy = (real'(a) * 61.0 + real'(m) * 37.0) * PI / 180.0;
                mag  = (m == 0) ? 900.0 : 2500.0;
                update(rnd(mag * $cos(ang)), rnd(mag * $sin(ang)),
                       rnd(1800.0 * $cos(angy)), rnd(1800.0 * $sin(angy)), 0, "sweep");
            end
        end

        // samples exactly on the axes, including the negative real axis (R4)
        update(-1500, 0, 400, -700, 0, "R4 neg real axis");
        update(0, -1500, -900, 200, 0, "R4 neg imag axis");
        update(0, 1500, 600, 600, 0, "R4 pos imag axis");

        // all-zero boundary sample bypasses the rotations (R5)
        update(0, 0, 777, -333, 0, "R5 zero sample");

        // a second in_valid during the busy window is ignored (R7)
        update(700, 900, -500, 800, 6, "R7 busy poke");
        dsave  = int'(diag);
        orsave = int'(off_re);
        oisave = int'(off_im);
        extra  = 0;
        for (int k = 0; k < LAT + 6; k++) begin
            @(negedge clk);
            if (out_valid) extra++;
        end
        chk("R7 no extra pulse", extra, 0.0, 0);
        chk("R7 diag kept", int'(diag), real'(dsave), 0);
        chk("R7 off_re kept", int'(off_re), real'(orsave), 0);
        chk("R7 off_im kept", int'(off_im), real'(oisave), 0);

        // one more normal update after the ignored pulse
        update(-2000, 1300, 1000, 1000, 0, "after poke");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(10 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule